// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block runs a linked list of DMA segment descriptors stored in memory. It is given a starting descriptor address and a start pulse. It then reads one descriptor, copies that segment's bytes from the source address to the destination address one 32-bit word at a time, and moves on to the descriptor that the segment names. It stops after the descriptor that carries the last-descriptor flag.

Every descriptor address is aligned to 32 bytes. Because of this, the five low bits of the link word are free to carry per-segment control: the last-descriptor flag, an end-of-segment interrupt enable and a snoop attribute for the segment's data traffic. Descriptor reads and data moves all use a single request/acknowledge memory port that allows one transaction at a time.

Top module: `dma_chain_seq`

## Requirements
- R1: After a start, the descriptor is read with four reads at consecutive word addresses from the current descriptor address. The words are taken in this order: source address, destination address, link word, byte count (count in bits 25:0).
- R2: Each data beat is a read at the source address followed by a write of the same data to the destination address. Both addresses advance by 4 after each beat.
- R3: The 26-bit byte count decreases after each data read, by 4, or by the remaining count when fewer than 4 bytes are left. The segment ends when the count reaches zero, so a count of N takes ceil(N/4) beats.
- R4: A byte count of zero at fetch ends the segment with no data beat.
- R5: When the link word's bit 0 is clear, the next descriptor is fetched from the link word with bits 4:0 forced to zero. Reserved bits 2:1 have no effect.
- R6: When bit 0 of the link word is set, the chain stops after that segment. done goes high, busy goes low, and no further request is made.
- R7: When bit 3 of the link word is set, irq goes high at the end of that segment and stays high until irq_clr is pulsed. When bit 3 is clear, the segment raises no interrupt.
- R8: When bit 4 of the link word is set, mem_snoop is high on that segment's data reads and writes. It is low on descriptor reads and on the data beats of segments that have bit 4 clear.
- R9: A start pulse while busy is ignored.
- R10: A start whose base address has nonzero bits 4:0 sets err and makes no memory request. busy stays low.
- R11: After reset, busy, done, err, irq and mem_req are low. A valid start clears done and err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| base_addr | input | 32 | First descriptor address |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Last segment completed |
| err | output | 1 | Misaligned base at start |
| irq | output | 1 | End-of-segment interrupt, level |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_snoop | output | 1 | Snoopable attribute of the transaction |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions assume that mem_ack is only returned while mem_req is high, and that read data is valid in the same cycle as the acknowledge. They also assume that the memory never completes more than one transaction per request. The bench memory model meets these conditions. It acknowledges only a pending request, one cycle after that request appears, and drops the acknowledge in the next cycle. It drives mem_rdata from its array at the same moment it raises mem_ack.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 32,
  parameter int CW = 26,
  parameter int ALIGN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          irq_clr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_snoop,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_END} st_t;

  localparam logic [CW-1:0] BEAT = CW'(4);

  st_t           st_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] cur_q, src_q, dst_q;
  logic [31:0]   lnk_q, dat_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] step;

  assign step      = (cnt_q < BEAT) ? cnt_q : BEAT;
  assign busy      = (st_q != S_IDLE);
  assign mem_req   = (st_q == S_FETCH) || (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_wdata = dat_q;
  assign mem_snoop = lnk_q[4] && ((st_q == S_RD) || (st_q == S_WR));
  assign mem_addr  = (st_q == S_FETCH) ? cur_q + {{(AW-4){1'b0}}, idx_q, 2'b00} :
                     (st_q == S_WR)    ? dst_q : src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      cur_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      lnk_q <= '0;
      dat_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          if (base_addr[ALIGN-1:0] != '0) begin
            err  <= 1'b1;
            done <= 1'b0;
          end else begin
            err   <= 1'b0;
            done  <= 1'b0;
            cur_q <= base_addr;
            idx_q <= '0;
            lnk_q <= '0;
            st_q  <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          case (idx_q)
            2'd0: src_q <= mem_rdata[AW-1:0];
            2'd1: dst_q <= mem_rdata[AW-1:0];
            2'd2: lnk_q <= mem_rdata;
            default: cnt_q <= mem_rdata[CW-1:0];
          endcase
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) st_q <= (mem_rdata[CW-1:0] == '0) ? S_END : S_RD;
        end
        S_RD: if (mem_ack) begin
          dat_q <= mem_rdata;
          cnt_q <= cnt_q - step;
          src_q <= src_q + AW'(4);
          st_q  <= S_WR;
        end
        S_WR: if (mem_ack) begin
          dst_q <= dst_q + AW'(4);
          st_q  <= (cnt_q == '0) ? S_END : S_RD;
        end
        default: begin
          if (lnk_q[3]) irq <= 1'b1;
          if (lnk_q[0]) begin
            done <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            cur_q <= {lnk_q[AW-1:ALIGN], {ALIGN{1'b0}}};
            idx_q <= '0;
            st_q  <= S_FETCH;
          end
        end
      endcase
    end
  end

  a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_q[ALIGN-1:0] == '0);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r3_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD && mem_ack) |=> (cnt_q < $past(cnt_q)));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r8_snoop_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_snoop |-> (mem_req && st_q != S_FETCH));
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
  logic clk = 0, rst_n = 0, start = 0, irq_clr = 0, mem_ack = 0;
  logic [31:0] base_addr = 0, mem_rdata = 0;
  logic busy, done, err, irq, mem_req, mem_we, mem_snoop;
  logic [31:0] mem_addr, mem_wdata;

  always #2.5 clk = ~clk;

  dma_chain_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .irq_clr(irq_clr), .busy(busy), .done(done), .err(err), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_snoop(mem_snoop), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [31:0] mem [0:1023];
  logic [31:0] log_a [0:63];
  logic        log_w [0:63];
  logic        log_s [0:63];
  int n_log = 0, tests = 0, fails = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && rst_n) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      if (n_log < 64) begin
        log_a[n_log] <= mem_addr; log_w[n_log] <= mem_we; log_s[n_log] <= mem_snoop;
      end
      n_log <= n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [31:0] b);
    @(negedge clk); n_log = 0; base_addr = b; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !irq && !mem_req, "R11 reset outputs",
        {27'b0, busy, done, err, irq, mem_req}, 0);
  endtask

  task automatic t_misalign();
    go(32'h44);
    @(negedge clk);
    chk(err == 1, "R10 err set", err, 1);
    chk(!busy, "R10 busy low", busy, 0);
    chk(n_log == 0, "R10 no request", n_log, 0);
  endtask

  task automatic t_single();
    mem[32'h40 >> 2] = 32'h200; mem[32'h44 >> 2] = 32'h300;
    mem[32'h48 >> 2] = 32'h1;   mem[32'h4C >> 2] = 32'd12;
    for (int i = 0; i < 3; i++) begin mem[(32'h200 >> 2) + i] = 32'hA0A0_0000 + i; mem[(32'h300 >> 2) + i] = 0; end
    go(32'h40);
    chk(busy && !err, "R11 busy, err cleared", {busy, err}, 2);
    wait_idle();
    chk(n_log == 10, "R3 12 bytes -> 3 beats", n_log, 10);
    for (int i = 0; i < 4; i++)
      chk(log_a[i] == 32'h40 + 4 * i && !log_w[i], "R1 fetch order", log_a[i], 32'h40 + 4 * i);
    for (int i = 0; i < 3; i++) begin
      chk(log_a[4 + 2 * i] == 32'h200 + 4 * i && !log_w[4 + 2 * i], "R2 read addr", log_a[4 + 2 * i], 32'h200 + 4 * i);
      chk(log_a[5 + 2 * i] == 32'h300 + 4 * i && log_w[5 + 2 * i], "R2 write addr", log_a[5 + 2 * i], 32'h300 + 4 * i);
      chk(mem[(32'h300 >> 2) + i] == 32'hA0A0_0000 + i, "R2 data copied", mem[(32'h300 >> 2) + i], 32'hA0A0_0000 + i);
    end
    chk(done && !busy, "R6 done after last", {done, busy}, 2);
    chk(!irq, "R7 no irq when bit3 clear", irq, 0);
    for (int i = 0; i < 10; i++) chk(!log_s[i], "R8 snoop low", log_s[i], 0);
  endtask

  task automatic t_chain();
    mem[32'h80 >> 2] = 32'h200; mem[32'h84 >> 2] = 32'h300;
    mem[32'h88 >> 2] = 32'hD6;  mem[32'h8C >> 2] = 32'd5;
    mem[32'hC0 >> 2] = 32'h280; mem[32'hC4 >> 2] = 32'h380;
    mem[32'hC8 >> 2] = 32'h9;   mem[32'hCC >> 2] = 32'd0;
    mem[32'h200 >> 2] = 32'h1111_2222; mem[32'h204 >> 2] = 32'h3333_4444;
    mem[32'h300 >> 2] = 0; mem[32'h304 >> 2] = 0;
    go(32'h80);
    chk(!done, "R11 done cleared", done, 0);
    repeat (3) @(negedge clk);
    start = 1; base_addr = 32'h100; @(negedge clk); start = 0;
    wait_idle();
    chk(n_log == 12, "R4 zero count no beats", n_log, 12);
    chk(log_a[4] == 32'h200 && log_a[6] == 32'h204, "R3 5 bytes -> 2 beats", log_a[6], 32'h204);
    for (int i = 0; i < 4; i++)
      chk(log_a[8 + i] == 32'hC0 + 4 * i && !log_w[8 + i], "R5 next fetch masked", log_a[8 + i], 32'hC0 + 4 * i);
    chk(log_a[0] == 32'h80, "R9 start while busy ignored", log_a[0], 32'h80);
    for (int i = 0; i < 12; i++)
      chk(log_s[i] == (i >= 4 && i < 8), "R8 snoop per segment", log_s[i], (i >= 4 && i < 8));
    chk(mem[32'h304 >> 2] == 32'h3333_4444, "R2 chain data", mem[32'h304 >> 2], 32'h3333_4444);
    chk(irq, "R7 irq raised", irq, 1);
    chk(done && !mem_req, "R6 stop after eot", {done, mem_req}, 2);
    repeat (3) @(negedge clk);
    chk(irq, "R7 irq held", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    chk(!irq, "R7 irq cleared", irq, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_misalign();
    t_single();
    t_chain();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule